// File: doc/BRIEF.md
# Decode-Stage Operand Forwarding and Stall Unit

This combinational block resolves the two source operands of the decode stage in a five-stage in-order pipeline. Each operand arrives as a 6-bit register address plus a use flag. The block compares that address with the destinations still in flight in the decode, execute and memory stages. It then delivers one of two things: the in-flight value, or the register-file read value when no stage holds a pending write.

Every in-flight producer carries a 2-bit availability level. The level names the stage in which its result can first be forwarded. A producer whose value does not yet exist in its current stage raises a stall request instead of forwarding. The unit also steers the memory-stage result to one of two register banks, the general bank or the coprocessor bank. An interrupt input suppresses that write.

The pipeline registers and the register banks sit outside this block, and so does the stall logic.

Top module: `fwd_hazard_unit`

## Requirements
- R1: An operand whose use flag is 0 never forwards and never raises `stall_o`. Its output is the bank read value.
- R2: Address bit 5 selects the bank: 0 is the general bank, 1 is the coprocessor bank. The 5-bit bank read address is `src_addr[4:0]`. With no forwarding, the operand output is the read data of the selected bank.
- R3: Address 6'b000000 is general register 0. It always reads as zero, never forwards and never stalls. Coprocessor register 0 (6'h20) is an ordinary register.
- R4: When several producers that have their write enable set target the operand's register, decode has priority over execute, and execute has priority over memory.
- R5: The availability levels are: 2'b11 = value ready in decode, 2'b10 = ready in execute, 2'b01 = ready in memory, 2'b00 = bank only. Stages carry the codes decode=3, execute=2 and memory=1. The highest-priority matching producer forwards its data when its level is greater than or equal to its stage code.
- R6: When the highest-priority match has a level below its stage code, `stall_o` is 1. An older producer that is ready does not cancel the stall.
- R7: A producer whose write enable is 0 is ignored for both forwarding and stalling.
- R8: `stall_o` is the OR of the stall conditions of the two operands.
- R9: Writeback always drives `wb_addr_o = mem_addr_i[4:0]` and `wb_data_o = mem_data_i`. When the memory-stage write enable is 1, exactly one strobe rises: the general strobe when `mem_addr_i[5]` is 0, the coprocessor strobe when it is 1.
- R10: While `irq_i` is 1, both write strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_addr_i | input | 6 | operand A register address |
| src_a_use_i | input | 1 | operand A is needed |
| src_b_addr_i | input | 6 | operand B register address |
| src_b_use_i | input | 1 | operand B is needed |
| dec_addr_i | input | 6 | decode-stage pending destination |
| dec_wen_i | input | 1 | decode-stage write enable |
| dec_lvl_i | input | 2 | decode-stage availability level |
| dec_data_i | input | 32 | decode-stage value |
| exe_addr_i | input | 6 | execute-stage pending destination |
| exe_wen_i | input | 1 | execute-stage write enable |
| exe_lvl_i | input | 2 | execute-stage availability level |
| exe_data_i | input | 32 | execute-stage result |
| mem_addr_i | input | 6 | memory-stage pending destination |
| mem_wen_i | input | 1 | memory-stage write enable |
| mem_lvl_i | input | 2 | memory-stage availability level |
| mem_data_i | input | 32 | memory-stage write data |
| irq_i | input | 1 | interrupt, blocks writeback |
| gpr_rd_a_i | input | 32 | general bank read data, port A |
| cop_rd_a_i | input | 32 | coprocessor bank read data, port A |
| gpr_rd_b_i | input | 32 | general bank read data, port B |
| cop_rd_b_i | input | 32 | coprocessor bank read data, port B |
| rd_addr_a_o | output | 5 | bank read address, port A |
| rd_addr_b_o | output | 5 | bank read address, port B |
| opnd_a_o | output | 32 | resolved operand A |
| opnd_b_o | output | 32 | resolved operand B |
| stall_o | output | 1 | pipeline stall request |
| wb_addr_o | output | 5 | writeback address |
| wb_data_o | output | 32 | writeback data |
| wb_gpr_we_o | output | 1 | general bank write strobe |
| wb_cop_we_o | output | 1 | coprocessor bank write strobe |

## Verification
The stage-priority tests give all three stages the same target and then remove producers one at a time. This shows that decode wins over execute and execute wins over memory. The level tests place each level code in each stage, which separates a forward from a stall at every stage boundary. They also place a ready older producer behind a younger one that is not ready, so a design that falls through to the older stage fails. Register-0, coprocessor-register-0, disabled-use and disabled-write cases separate the bank path from the forward path. Writeback cases flip the bank bit and the interrupt.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int DATA_W  = 32;
  localparam int REG_AW  = 6;
  localparam int BANK_AW = REG_AW - 1;
  localparam int N_STG   = 3;

  typedef enum logic [1:0] {
    LVL_BANK = 2'b00,
    LVL_MEM  = 2'b01,
    LVL_EXE  = 2'b10,
    LVL_DEC  = 2'b11
  } avail_lvl_e;

  typedef struct packed {
    logic [REG_AW-1:0] addr;
    logic              wen;
    avail_lvl_e        lvl;
    logic [DATA_W-1:0] data;
  } producer_t;
endpackage

// File: rtl/fwd_stage_cmp.sv
module fwd_stage_cmp
  import fwd_pkg::*;
#(
  parameter logic [1:0] STAGE_LVL = 2'b11
) (
  input  logic [REG_AW-1:0] src_addr_i,
  input  logic              src_use_i,
  input  logic [REG_AW-1:0] prod_addr_i,
  input  logic              prod_wen_i,
  input  logic [1:0]        prod_lvl_i,
  output logic              hit_o,
  output logic              ready_o
);
  // register 0 of the general bank is hard-wired, never a forwarding target
  assign hit_o   = src_use_i && prod_wen_i && (prod_addr_i == src_addr_i) && (src_addr_i != '0);
  assign ready_o = prod_lvl_i >= STAGE_LVL;
endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
  import fwd_pkg::*;
#(
  parameter int NS = N_STG
) (
  input  logic [REG_AW-1:0]  src_addr_i,
  input  logic               src_use_i,
  input  producer_t          prod_i [NS],
  input  logic [DATA_W-1:0]  gpr_rd_i,
  input  logic [DATA_W-1:0]  cop_rd_i,
  output logic [BANK_AW-1:0] rd_addr_o,
  output logic [DATA_W-1:0]  data_o,
  output logic               hazard_o
);
  logic [NS-1:0] hit, ready;
  logic [DATA_W-1:0] bank_val;
  logic found;

  for (genvar s = 0; s < NS; s++) begin : g_stg
    // index 0 is the youngest stage, which has the highest level code
    fwd_stage_cmp #(.STAGE_LVL(2'(NS - s))) u_cmp (
      .src_addr_i (src_addr_i),
      .src_use_i  (src_use_i),
      .prod_addr_i(prod_i[s].addr),
      .prod_wen_i (prod_i[s].wen),
      .prod_lvl_i (prod_i[s].lvl),
      .hit_o      (hit[s]),
      .ready_o    (ready[s])
    );
  end

  assign rd_addr_o = src_addr_i[BANK_AW-1:0];

  always_comb begin
    if (src_addr_i[BANK_AW])   bank_val = cop_rd_i;
    else if (src_addr_i == '0) bank_val = '0;
    else                       bank_val = gpr_rd_i;
  end

  always_comb begin
    data_o   = bank_val;
    hazard_o = 1'b0;
    found    = 1'b0;
    for (int s = 0; s < NS; s++) begin
      if (!found && hit[s]) begin
        found = 1'b1;
        if (ready[s]) data_o   = prod_i[s].data;
        else          hazard_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fwd_wb_steer.sv
module fwd_wb_steer
  import fwd_pkg::*;
(
  input  logic [REG_AW-1:0]  mem_addr_i,
  input  logic               mem_wen_i,
  input  logic [DATA_W-1:0]  mem_data_i,
  input  logic               irq_i,
  output logic [BANK_AW-1:0] wb_addr_o,
  output logic [DATA_W-1:0]  wb_data_o,
  output logic               gpr_we_o,
  output logic               cop_we_o
);
  logic wr_ok;

  assign wr_ok     = mem_wen_i && !irq_i;
  assign wb_addr_o = mem_addr_i[BANK_AW-1:0];
  assign wb_data_o = mem_data_i;
  assign gpr_we_o  = wr_ok && !mem_addr_i[BANK_AW];
  assign cop_we_o  = wr_ok &&  mem_addr_i[BANK_AW];
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
  import fwd_pkg::*;
(
  input  logic [REG_AW-1:0]  src_a_addr_i,
  input  logic               src_a_use_i,
  input  logic [REG_AW-1:0]  src_b_addr_i,
  input  logic               src_b_use_i,
  input  logic [REG_AW-1:0]  dec_addr_i,
  input  logic               dec_wen_i,
  input  logic [1:0]         dec_lvl_i,
  input  logic [DATA_W-1:0]  dec_data_i,
  input  logic [REG_AW-1:0]  exe_addr_i,
  input  logic               exe_wen_i,
  input  logic [1:0]         exe_lvl_i,
  input  logic [DATA_W-1:0]  exe_data_i,
  input  logic [REG_AW-1:0]  mem_addr_i,
  input  logic               mem_wen_i,
  input  logic [1:0]         mem_lvl_i,
  input  logic [DATA_W-1:0]  mem_data_i,
  input  logic               irq_i,
  input  logic [DATA_W-1:0]  gpr_rd_a_i,
  input  logic [DATA_W-1:0]  cop_rd_a_i,
  input  logic [DATA_W-1:0]  gpr_rd_b_i,
  input  logic [DATA_W-1:0]  cop_rd_b_i,
  output logic [BANK_AW-1:0] rd_addr_a_o,
  output logic [BANK_AW-1:0] rd_addr_b_o,
  output logic [DATA_W-1:0]  opnd_a_o,
  output logic [DATA_W-1:0]  opnd_b_o,
  output logic               stall_o,
  output logic [BANK_AW-1:0] wb_addr_o,
  output logic [DATA_W-1:0]  wb_data_o,
  output logic               wb_gpr_we_o,
  output logic               wb_cop_we_o
);
  localparam int N_OPS = 2;

  producer_t          prod [N_STG];
  logic [REG_AW-1:0]  src_addr [N_OPS];
  logic [N_OPS-1:0]   src_use;
  logic [DATA_W-1:0]  gpr_rd [N_OPS];
  logic [DATA_W-1:0]  cop_rd [N_OPS];
  logic [BANK_AW-1:0] rd_addr [N_OPS];
  logic [DATA_W-1:0]  opnd [N_OPS];
  logic [N_OPS-1:0]   hazard;

  assign prod[0] = producer_t'{dec_addr_i, dec_wen_i, avail_lvl_e'(dec_lvl_i), dec_data_i};
  assign prod[1] = producer_t'{exe_addr_i, exe_wen_i, avail_lvl_e'(exe_lvl_i), exe_data_i};
  assign prod[2] = producer_t'{mem_addr_i, mem_wen_i, avail_lvl_e'(mem_lvl_i), mem_data_i};

  assign src_addr[0] = src_a_addr_i;
  assign src_addr[1] = src_b_addr_i;
  assign src_use     = {src_b_use_i, src_a_use_i};
  assign gpr_rd[0]   = gpr_rd_a_i;
  assign gpr_rd[1]   = gpr_rd_b_i;
  assign cop_rd[0]   = cop_rd_a_i;
  assign cop_rd[1]   = cop_rd_b_i;

  for (genvar k = 0; k < N_OPS; k++) begin : g_op
    fwd_operand_sel #(.NS(N_STG)) u_sel (
      .src_addr_i(src_addr[k]),
      .src_use_i (src_use[k]),
      .prod_i    (prod),
      .gpr_rd_i  (gpr_rd[k]),
      .cop_rd_i  (cop_rd[k]),
      .rd_addr_o (rd_addr[k]),
      .data_o    (opnd[k]),
      .hazard_o  (hazard[k])
    );
  end

  assign rd_addr_a_o = rd_addr[0];
  assign rd_addr_b_o = rd_addr[1];
  assign opnd_a_o    = opnd[0];
  assign opnd_b_o    = opnd[1];
  assign stall_o     = |hazard;

  fwd_wb_steer u_wb (
    .mem_addr_i(mem_addr_i),
    .mem_wen_i (mem_wen_i),
    .mem_data_i(mem_data_i),
    .irq_i     (irq_i),
    .wb_addr_o (wb_addr_o),
    .wb_data_o (wb_data_o),
    .gpr_we_o  (wb_gpr_we_o),
    .cop_we_o  (wb_cop_we_o)
  );
endmodule

// File: rtl/fwd_hazard_unit_chk.sv
module fwd_hazard_unit_chk
  import fwd_pkg::*;
(
  input logic [REG_AW-1:0] src_a_addr_i,
  input logic              src_a_use_i,
  input logic              src_b_use_i,
  input logic              dec_wen_i,
  input logic              exe_wen_i,
  input logic              mem_wen_i,
  input logic              irq_i,
  input logic [DATA_W-1:0] opnd_a_o,
  input logic              stall_o,
  input logic              wb_gpr_we_o,
  input logic              wb_cop_we_o
);
  always_comb begin
    if (!src_a_use_i && !src_b_use_i)
      assert_no_stall_unused_R1: assert (!stall_o);
    if (src_a_addr_i == '0)
      assert_reg0_zero_R3: assert (opnd_a_o == '0);
    if (!dec_wen_i && !exe_wen_i && !mem_wen_i)
      assert_idle_no_stall_R7: assert (!stall_o);
    assert_wb_one_bank_R9: assert (!(wb_gpr_we_o && wb_cop_we_o));
    if (!mem_wen_i)
      assert_wb_quiet_R9: assert (!wb_gpr_we_o && !wb_cop_we_o);
    if (irq_i)
      assert_irq_blocks_R10: assert (!wb_gpr_we_o && !wb_cop_we_o);
  end
endmodule

bind fwd_hazard_unit fwd_hazard_unit_chk u_chk (.*);

// File: tb/fwd_hazard_unit_tb.sv
`timescale 1ns/1ps
module fwd_hazard_unit_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [5:0]  src_a_addr, src_b_addr, dec_addr, exe_addr, mem_addr;
  logic        src_a_use, src_b_use, dec_wen, exe_wen, mem_wen, irq;
  logic [1:0]  dec_lvl, exe_lvl, mem_lvl;
  logic [31:0] dec_data, exe_data, mem_data, gpr_a, cop_a, gpr_b, cop_b;
  logic [4:0]  rd_addr_a, rd_addr_b, wb_addr;
  logic [31:0] opnd_a, opnd_b, wb_data;
  logic        stall, gwe, cwe;

  localparam logic [31:0] GA = 32'hA0A0_0001, CA = 32'hC0C0_0001;
  localparam logic [31:0] GB = 32'hA0A0_0002, CB = 32'hC0C0_0002;
  localparam logic [31:0] DD = 32'hD0D0_1111, ED = 32'hE0E0_2222, MD = 32'h3030_3333;

  fwd_hazard_unit u_dut (
    .src_a_addr_i(src_a_addr), .src_a_use_i(src_a_use),
    .src_b_addr_i(src_b_addr), .src_b_use_i(src_b_use),
    .dec_addr_i(dec_addr), .dec_wen_i(dec_wen), .dec_lvl_i(dec_lvl), .dec_data_i(dec_data),
    .exe_addr_i(exe_addr), .exe_wen_i(exe_wen), .exe_lvl_i(exe_lvl), .exe_data_i(exe_data),
    .mem_addr_i(mem_addr), .mem_wen_i(mem_wen), .mem_lvl_i(mem_lvl), .mem_data_i(mem_data),
    .irq_i(irq),
    .gpr_rd_a_i(gpr_a), .cop_rd_a_i(cop_a), .gpr_rd_b_i(gpr_b), .cop_rd_b_i(cop_b),
    .rd_addr_a_o(rd_addr_a), .rd_addr_b_o(rd_addr_b),
    .opnd_a_o(opnd_a), .opnd_b_o(opnd_b), .stall_o(stall),
    .wb_addr_o(wb_addr), .wb_data_o(wb_data),
    .wb_gpr_we_o(gwe), .wb_cop_we_o(cwe)
  );

  typedef struct {
    string       tag;
    logic        chk_ops;
    logic [31:0] a, b;
    logic        stall;
    logic        gwe, cwe;
    logic [4:0]  ra, rb, wa;
    logic [31:0] wd;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic set_base();
    src_a_addr = '0; src_b_addr = '0; src_a_use = 1'b0; src_b_use = 1'b0;
    dec_addr = '0; exe_addr = '0; mem_addr = '0;
    dec_wen = 1'b0; exe_wen = 1'b0; mem_wen = 1'b0; irq = 1'b0;
    dec_lvl = '0; exe_lvl = '0; mem_lvl = '0;
    dec_data = DD; exe_data = ED; mem_data = MD;
    gpr_a = GA; cop_a = CA; gpr_b = GB; cop_b = CB;
  endtask

  // expected values are written per test from the requirements
  task automatic push(input string tag, input logic chk_ops, input logic [31:0] a,
                      input logic [31:0] b, input logic st, input logic g, input logic c);
    exp_t e;
    e.tag = tag; e.chk_ops = chk_ops; e.a = a; e.b = b; e.stall = st;
    e.gwe = g; e.cwe = c;
    e.ra = src_a_addr[4:0]; e.rb = src_b_addr[4:0];
    e.wa = mem_addr[4:0]; e.wd = mem_data;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      bit bad;
      e = q.pop_front();
      bad = 1'b0;
      checks++;
      if (e.chk_ops && opnd_a !== e.a) begin
        $display("FAIL %s opnd_a act=%h exp=%h", e.tag, opnd_a, e.a); bad = 1'b1;
      end
      if (e.chk_ops && opnd_b !== e.b) begin
        $display("FAIL %s opnd_b act=%h exp=%h", e.tag, opnd_b, e.b); bad = 1'b1;
      end
      if (stall !== e.stall) begin
        $display("FAIL %s stall act=%b exp=%b", e.tag, stall, e.stall); bad = 1'b1;
      end
      if (gwe !== e.gwe || cwe !== e.cwe) begin
        $display("FAIL %s strobes act=%b%b exp=%b%b", e.tag, gwe, cwe, e.gwe, e.cwe); bad = 1'b1;
      end
      if (rd_addr_a !== e.ra || rd_addr_b !== e.rb) begin
        $display("FAIL %s rd_addr act=%h/%h exp=%h/%h", e.tag, rd_addr_a, rd_addr_b, e.ra, e.rb);
        bad = 1'b1;
      end
      if (wb_addr !== e.wa || wb_data !== e.wd) begin
        $display("FAIL %s wb act=%h/%h exp=%h/%h", e.tag, wb_addr, wb_data, e.wa, e.wd);
        bad = 1'b1;
      end
      if (bad) fails++;
    end
  end

  task automatic step();
    @(posedge clk); #1;
    set_base();
  endtask

  initial begin
    set_base();
    // idle state: register 0 reads zero, no stall, no strobes
    step(); push("R3 idle", 1, 0, 0, 0, 0, 0);

    // R1: unused operands ignore matching producers
    step();
    src_a_addr = 6'd5; dec_addr = 6'd5; dec_wen = 1; dec_lvl = 2'b11;
    src_b_addr = 6'd5; exe_addr = 6'd5; exe_wen = 1; exe_lvl = 2'b00;
    push("R1 use low", 1, GA, GB, 0, 0, 0);

    // R2: bank select and read addresses
    step();
    src_a_addr = 6'h25; src_a_use = 1; src_b_addr = 6'h05; src_b_use = 1;
    push("R2 bank sel", 1, CA, GB, 0, 0, 0);

    // R3: general reg 0 never forwards or stalls
    step();
    src_a_use = 1; src_b_use = 1;
    dec_wen = 1; dec_lvl = 2'b11; exe_wen = 1; exe_lvl = 2'b00;
    push("R3 reg0", 1, 0, 0, 0, 0, 0);
    // R3: coprocessor register 0 forwards normally
    step();
    src_a_addr = 6'h20; src_a_use = 1; dec_addr = 6'h20; dec_wen = 1; dec_lvl = 2'b11;
    push("R3 cop reg0", 1, DD, 0, 0, 0, 0);

    // R4: priority decode > execute > memory
    step();
    src_a_addr = 6'd7; src_a_use = 1;
    dec_addr = 6'd7; dec_wen = 1; dec_lvl = 2'b11;
    exe_addr = 6'd7; exe_wen = 1; exe_lvl = 2'b11;
    mem_addr = 6'd7; mem_lvl = 2'b11;
    push("R4 dec wins", 1, DD, 0, 0, 0, 0);
    step();
    src_a_addr = 6'd7; src_a_use = 1;
    exe_addr = 6'd7; exe_wen = 1; exe_lvl = 2'b11;
    mem_addr = 6'd7; mem_wen = 1; mem_lvl = 2'b11;
    push("R4 exe wins", 1, ED, 0, 0, 1, 0);

    // R5: ready at each stage boundary
    step();
    src_b_addr = 6'd9; src_b_use = 1; exe_addr = 6'd9; exe_wen = 1; exe_lvl = 2'b10;
    push("R5 exe lvl10", 1, 0, ED, 0, 0, 0);
    step();
    src_b_addr = 6'd9; src_b_use = 1; mem_addr = 6'd9; mem_wen = 1; mem_lvl = 2'b01;
    push("R5 mem lvl01", 1, 0, MD, 0, 1, 0);

    // R6: not-ready youngest match stalls, older ready producer does not help
    step();
    src_a_addr = 6'd3; src_a_use = 1;
    dec_addr = 6'd3; dec_wen = 1; dec_lvl = 2'b10;
    exe_addr = 6'd3; exe_wen = 1; exe_lvl = 2'b11;
    push("R6 dec not ready", 0, 0, 0, 1, 0, 0);
    step();
    src_a_addr = 6'd3; src_a_use = 1; exe_addr = 6'd3; exe_wen = 1; exe_lvl = 2'b01;
    push("R6 exe not ready", 0, 0, 0, 1, 0, 0);
    step();
    src_a_addr = 6'd3; src_a_use = 1; mem_addr = 6'd3; mem_wen = 1; mem_lvl = 2'b00;
    push("R6 mem not ready", 0, 0, 0, 1, 1, 0);

    // R7: write enable low is ignored
    step();
    src_a_addr = 6'd4; src_a_use = 1; dec_addr = 6'd4; dec_lvl = 2'b10;
    exe_addr = 6'd4; exe_wen = 1; exe_lvl = 2'b10;
    push("R7 wen low", 1, ED, 0, 0, 0, 0);

    // R8: stall from operand B only, operand A still forwarded
    step();
    src_a_addr = 6'd1; src_a_use = 1; src_b_addr = 6'd2; src_b_use = 1;
    dec_addr = 6'd1; dec_wen = 1; dec_lvl = 2'b11;
    exe_addr = 6'd2; exe_wen = 1; exe_lvl = 2'b01;
    push("R8 b stalls", 0, 0, 0, 1, 0, 0);
    if (1) begin end

    // R9: writeback steering
    step();
    mem_addr = 6'h0B; mem_wen = 1; mem_lvl = 2'b01;
    push("R9 gpr wb", 1, 0, 0, 0, 1, 0);
    step();
    mem_addr = 6'h2B; mem_wen = 1; mem_lvl = 2'b01;
    push("R9 cop wb", 1, 0, 0, 0, 0, 1);

    // R10: interrupt blocks both strobes
    step();
    mem_addr = 6'h0B; mem_wen = 1; irq = 1;
    push("R10 irq gpr", 1, 0, 0, 0, 0, 0);
    step();
    mem_addr = 6'h2B; mem_wen = 1; irq = 1;
    push("R10 irq cop", 1, 0, 0, 0, 0, 0);

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule